// File: doc/BRIEF.md
# Sample FIFO with Sticky Overflow

This block holds four result buffers, one for each sample sequencer, together with the overflow status word that belongs to them. A conversion engine pushes a result into one buffer by pulsing that buffer's write strobe while it drives the shared data bus. The register interface pops results by pulsing a per-buffer read strobe. The popped result appears on that buffer's output lane one cycle later.

When a buffer is already full and a write arrives with no pop in the same cycle, the incoming sample is thrown away. The samples already held are kept as they are, and a sticky flag for that buffer is raised. Software reads the flags from a 32-bit status word, with buffer n on bit n. A flag stays set until software writes a 1 to its bit position. Each buffer reports its own full and empty state, and each buffer's depth is a separate parameter.

Top module: `sfb_top`

## Requirements
- R1: Each buffer returns samples in the order they were written. A pop strobe in cycle t puts the oldest sample on that buffer's lane of `rd_data` from the clock edge that ends cycle t.
- R2: A write to a full buffer with no pop in the same cycle sets bit n of `ovf_status`, where n is the buffer index (0 to 3), from the next clock edge.
- R3: The sample in an overflowing write is discarded. The stored samples and their order are unchanged.
- R4: A set flag stays set until `ovf_clr_we` is pulsed with bit n of `ovf_clr_data` equal to 1. Writing 0 to a bit leaves that bit unchanged.
- R5: After reset all flags are 0, every buffer is empty and not full, and `rd_data` is 0. Bits 31:4 of `ovf_status` always read 0.
- R6: A write and a pop to a full buffer in the same cycle accept the write and pop the oldest sample. No overflow flag is raised, and the buffer stays full.
- R7: An overflow in the same cycle as a clear of that buffer's flag leaves the flag set.
- R8: `fifo_full[n]` is 1 exactly when buffer n holds its depth in samples. `fifo_empty[n]` is 1 exactly when buffer n holds none.
- R9: A pop from an empty buffer leaves its lane of `rd_data` at the last value read, and the buffer stays empty.
- R10: Buffer depths are set per buffer by `DEPTH_CFG`, one byte per buffer with buffer n in bits 8n+7:8n. The defaults are 8, 4, 2 and 1 for buffers 0 to 3.
- R11: The buffers are independent. Traffic or an overflow on one buffer changes no other buffer's contents, flags or full/empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 4 | Per-buffer write strobe |
| wr_data | input | DATA_W | Sample written by any strobed buffer |
| rd_strobe | input | 4 | Per-buffer pop strobe |
| rd_data | output | 4*DATA_W | Popped samples, buffer n in lane n |
| fifo_full | output | 4 | Per-buffer full indication |
| fifo_empty | output | 4 | Per-buffer empty indication |
| ovf_clr_we | input | 1 | Write enable for the status word (write one to clear) |
| ovf_clr_data | input | 32 | Write data; each 1 in bits 3:0 clears that flag |
| ovf_status | output | 32 | Sticky overflow flags in bits 3:0, zeros above |

## Verification
The scoreboard models every buffer as a queue of the depth that buffer is built with. Plain write-then-drain traffic shows whether ordering is kept. Overfilling a buffer shows whether the newest or the oldest sample is dropped. A combined write and pop on a full buffer separates a correct full test from one that ignores the pop. Clears are tried with a 0 bit, with stray upper bits, and in the same cycle as a fresh overflow, which tells a sticky flag apart from a level flag and shows whether set wins over clear. Buffers of depth 1, 2, 4 and 8 are each filled to their own limit, so a depth mix-up or cross-talk between buffers shows up as a wrong flag or a wrong sample.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int unsigned NUM_SEQ  = 4;
  localparam int unsigned STAT_W   = 32;
  localparam int unsigned DCFG_W   = 8;

  typedef logic [NUM_SEQ-1:0] seq_vec_t;
endpackage

// File: rtl/sfb_seq_fifo.sv
module sfb_seq_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_rd = rd_en & ~empty;
  assign do_wr = wr_en & (~full | do_rd);
  assign drop  = wr_en & full & ~do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      unique case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: a dropped write leaves the occupancy and write position alone
  a_r3_drop_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> ($stable(count) && $stable(wr_ptr)));

  // R6: write plus pop on a full buffer keeps it full
  a_r6_full_rdwr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && full) |=> full);

  // R9: pop on empty changes nothing
  a_r9_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && empty) |=> (empty && $stable(rd_data)));
endmodule

// File: rtl/sfb_ovf_status.sv
module sfb_ovf_status #(
  parameter int unsigned NUM = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set_vec,
  input  logic           clr_we,
  input  logic [NUM-1:0] clr_mask,
  output logic [NUM-1:0] flags
);
  logic [NUM-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | set_vec;
  end

  // R4: a flag not being cleared never falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flags) & ~$past(clr_eff)) & ~flags) == '0));

  // R7: a set request always lands, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_vec) & ~flags) == '0));
endmodule

// File: rtl/sfb_top.sv
module sfb_top #(
  parameter int unsigned DATA_W    = 16,
  parameter logic [31:0] DEPTH_CFG = {8'd1, 8'd2, 8'd4, 8'd8}
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [sfb_pkg::NUM_SEQ-1:0]        wr_strobe,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [sfb_pkg::NUM_SEQ-1:0]        rd_strobe,
  output logic [sfb_pkg::NUM_SEQ*DATA_W-1:0] rd_data,
  output logic [sfb_pkg::NUM_SEQ-1:0]        fifo_full,
  output logic [sfb_pkg::NUM_SEQ-1:0]        fifo_empty,
  input  logic                            ovf_clr_we,
  input  logic [sfb_pkg::STAT_W-1:0]         ovf_clr_data,
  output logic [sfb_pkg::STAT_W-1:0]         ovf_status
);
  import sfb_pkg::*;

  seq_vec_t drop_vec;
  seq_vec_t flag_vec;
  logic     clr_hi_unused;

  assign clr_hi_unused = ^ovf_clr_data[STAT_W-1:NUM_SEQ];

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    localparam int unsigned D = int'(DEPTH_CFG[g*DCFG_W +: DCFG_W]);

    sfb_seq_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (D)
    ) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_strobe[g]),
      .wr_data (wr_data),
      .rd_en   (rd_strobe[g]),
      .rd_data (rd_data[g*DATA_W +: DATA_W]),
      .full    (fifo_full[g]),
      .empty   (fifo_empty[g]),
      .drop    (drop_vec[g])
    );

    // R2: a dropped write shows in the status word's bit for this buffer
    a_r2_flag_follows_drop: assert property (@(posedge clk) disable iff (rst)
      drop_vec[g] |=> ovf_status[g]);
  end

  sfb_ovf_status #(
    .NUM (NUM_SEQ)
  ) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (drop_vec),
    .clr_we   (ovf_clr_we),
    .clr_mask (ovf_clr_data[NUM_SEQ-1:0]),
    .flags    (flag_vec)
  );

  assign ovf_status = {{(STAT_W-NUM_SEQ){1'b0}}, flag_vec};
endmodule

// File: tb/sfb_top_bench.sv
module sfb_top_bench;
  localparam int DW = 16;
  localparam int DEP [4] = '{8, 4, 2, 1};

  logic          clk = 0;
  logic          rst = 1;
  logic [3:0]    wr_strobe = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    rd_strobe = '0;
  logic [4*DW-1:0] rd_data;
  logic [3:0]    fifo_full, fifo_empty;
  logic          ovf_clr_we = 0;
  logic [31:0]   ovf_clr_data = '0;
  logic [31:0]   ovf_status;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] model [4][$];
  logic [DW-1:0] last_rd [4];
  logic [31:0]   exp_flags = '0;

  int            q_seq [$];
  logic [DW-1:0] q_val [$];
  string         q_tag [$];
  logic [3:0]    seen;

  sfb_top u_sfb_top (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .ovf_clr_we(ovf_clr_we),
    .ovf_clr_data(ovf_clr_data), .ovf_status(ovf_status)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected-read scoreboard whenever a pop was strobed
  always @(posedge clk) begin
    seen = rd_strobe;
    #5;
    for (int s = 0; s < 4; s++) begin
      if (seen[s]) begin
        if (q_seq.size() == 0) begin
          tests++; fails++;
          $display("FAIL R1 unexpected pop on %0d actual=1 expected=0", s);
        end else begin
          chk(q_tag.pop_front(), {16'h0, rd_data[q_seq.pop_front()*DW +: DW]},
              {16'h0, q_val.pop_front()});
        end
      end
    end
  end

  task automatic chk_state(string tag);
    logic [3:0] ef, ee;
    for (int s = 0; s < 4; s++) begin
      ef[s] = (model[s].size() == DEP[s]);
      ee[s] = (model[s].size() == 0);
    end
    chk({tag, " flags"}, ovf_status, exp_flags);
    chk({tag, " R8 full"}, {28'h0, fifo_full}, {28'h0, ef});
    chk({tag, " R8 empty"}, {28'h0, fifo_empty}, {28'h0, ee});
  endtask

  function automatic void exp_pop(int s, string tag);
    logic [DW-1:0] v;
    v = (model[s].size() != 0) ? model[s].pop_front() : last_rd[s];
    last_rd[s] = v;
    q_seq.push_back(s); q_val.push_back(v); q_tag.push_back(tag);
  endfunction

  function automatic void exp_push(int s, logic [DW-1:0] d, bit popping);
    if (model[s].size() < DEP[s] || popping) model[s].push_back(d);
    else exp_flags[s] = 1'b1;
  endfunction

  // Driver: one cycle per call, any mix of write, pop and clear
  task automatic op(int ws, logic [DW-1:0] d, int rs, bit cw, logic [31:0] cd,
                    string tag);
    @(negedge clk);
    wr_strobe = '0; rd_strobe = '0;
    if (ws >= 0) begin wr_strobe[ws] = 1'b1; wr_data = d; end
    if (rs >= 0) begin rd_strobe[rs] = 1'b1; exp_pop(rs, tag); end
    ovf_clr_we = cw; ovf_clr_data = cd;
    if (cw) exp_flags = exp_flags & ~{28'h0, cd[3:0]};
    if (ws >= 0) exp_push(ws, d, (rs == ws));
    @(negedge clk);
    wr_strobe = '0; rd_strobe = '0; ovf_clr_we = 0; ovf_clr_data = '0;
  endtask

  task automatic wr(int s, logic [DW-1:0] d);
    op(s, d, -1, 0, 0, "");
  endtask

  task automatic rd(int s, string tag);
    op(-1, 0, s, 0, 0, tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) last_rd[s] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_state("R5 reset");
    chk("R5 rd_data reset", rd_data[31:0], 32'h0);
    chk("R5 rd_data reset hi", rd_data[63:32], 32'h0);

    // R1 order on buffer 0
    wr(0, 16'h0101); wr(0, 16'h0202); wr(0, 16'h0303);
    chk_state("R1 after writes");
    rd(0, "R1 first"); rd(0, "R1 second"); rd(0, "R1 third");
    chk_state("R1 drained");

    // R2/R3 on depth-1 buffer 3
    wr(3, 16'hA003);
    chk_state("R10 depth1 full");
    wr(3, 16'hB003);
    chk_state("R2 ovf buffer 3 R11");
    rd(3, "R3 kept oldest on buffer 3");
    chk_state("R3 buffer 3 drained");

    // R4 writing zero leaves flag; stray upper bits harmless
    op(-1, 0, -1, 1, 32'hFFFF_FFF0, "");
    chk_state("R4 zero bit keeps flag");
    chk("R5 upper bits zero", {4'h0, ovf_status[31:4]}, 32'h0);
    op(-1, 0, -1, 1, 32'h0000_0008, "");
    chk_state("R4 clear flag 3");

    // Buffer 1 depth 4: fill, overflow, clear, combined write+pop
    for (int i = 0; i < 4; i++) wr(1, 16'h1100 + 16'(i));
    chk_state("R10 buffer1 full no ovf");
    wr(1, 16'h11FF);
    chk_state("R2 ovf buffer 1");
    op(-1, 0, -1, 1, 32'h2, "");
    chk_state("R4 clear flag 1");
    op(1, 16'h1144, 1, 0, 0, "R6 pop during write on full");
    chk_state("R6 no ovf on write+pop");
    for (int i = 0; i < 4; i++) rd(1, "R3 R6 order on buffer 1");
    chk_state("R11 buffer1 drained");

    // R7 on buffer 2 depth 2
    wr(2, 16'h2201); wr(2, 16'h2202);
    chk_state("R10 buffer2 full");
    op(2, 16'h22FF, -1, 1, 32'h4, "");
    exp_flags[2] = 1'b1;
    chk_state("R7 set beats clear");
    rd(2, "R3 buffer2 first"); rd(2, "R3 buffer2 second");

    // R9 empty pop holds last value
    rd(0, "R9 empty pop holds");
    chk_state("R9 still empty");

    // R10 buffer 0 depth 8 exactly
    for (int i = 0; i < 8; i++) wr(0, 16'h0A00 + 16'(i));
    chk_state("R10 buffer0 eight no ovf");
    wr(0, 16'h0AFF);
    chk_state("R10 buffer0 ninth ovf");
    for (int i = 0; i < 8; i++) rd(0, "R1 buffer0 deep order");
    op(-1, 0, -1, 1, 32'hF, "");
    chk_state("R4 clear all");

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", q_seq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule